// File: doc/BRIEF.md
# Annealing Batch Run Sequencer

This block drives one batch of annealing trials on a programmable optimization processor. A start request captures the batch settings: the cool-down length, the per-trial settle length, the ramp length and the trial count. The block then asks an external programming engine to load the problem and waits for that engine to report completion. After that it holds a cool-down interval, then repeats one trial loop for the requested number of trials. Each trial has three parts. First it waits so that the hardware can settle into its initial state. Then it sweeps a normalized schedule word from zero to full scale, which the shared analog line drivers follow. Last it requests a readout and writes the returned solution into the result slot whose index is the trial number.

All intervals are counted in clock cycles. As an example, at 50 MHz a 1 ms cool-down or settle is 50,000 cycles, a 100 µs ramp is 5,000 cycles, and a typical batch is 128 trials. A busy flag covers the whole batch. A one-cycle done pulse marks the end of the batch.

Top module: `anneal_seq`

## Requirements
- R1: After reset, and whenever no batch is running, `busy`, `done`, `progReq`, `rampActive`, `readReq` and `resWe` are low and `rampLevel` is zero.
- R2: A `start` sampled high while idle captures the four configuration inputs and begins the load phase. In the load phase `progReq` is high until a clock edge at which `progDone` is high, and only that edge ends the load phase.
- R3: From the edge that accepts `progDone`, the block spends exactly `cfgCool` cycles in cool-down and then `cfgSettle` cycles settling before the first ramp cycle. A configured count of zero acts as one.
- R4: `rampActive` is high for exactly `cfgRun` consecutive cycles per trial, where zero acts as one. In ramp cycle k (counting from 0) of a run length R > 1, `rampLevel` = floor(k·(2^RAMP_W−1)/(R−1)). When R = 1, the single ramp cycle shows full scale. The level therefore never decreases within a ramp and ends at full scale.
- R5: In the cycle after the last ramp cycle, `readReq` goes high and stays high until `readValid` is high. From the result write of one trial to the first ramp cycle of the next trial, exactly `cfgSettle` settle cycles pass.
- R6: In the cycle in which `readReq` and `readValid` are both high, `resWe` is high, `resAddr` equals the trial index (0 for the first trial, counting up by one) and `resData` equals `readData`. A batch writes exactly `cfgTrials` results, where zero acts as one.
- R7: `busy` is high from the cycle after `start` is accepted through the cycle of the last result write. In the next cycle `done` is high for exactly one cycle while `busy` is low, and then the block is idle.
- R8: While a batch runs, `start` pulses and changes on the configuration inputs have no effect on that batch, and no second batch follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a batch (acted on only while idle) |
| cfgCool | input | CNT_W | Cool-down length in cycles |
| cfgSettle | input | CNT_W | Per-trial settle length in cycles |
| cfgRun | input | CNT_W | Per-trial ramp length in cycles |
| cfgTrials | input | TRIAL_W | Number of trials in the batch |
| progReq | output | 1 | Load request to the programming engine |
| progDone | input | 1 | Programming engine reports the load complete |
| rampActive | output | 1 | High during ramp cycles |
| rampLevel | output | RAMP_W | Normalized schedule word, unsigned fraction |
| readReq | output | 1 | Readout request |
| readValid | input | 1 | Readout result is present on `readData` |
| readData | input | RES_W | Readout result |
| resWe | output | 1 | Result buffer write strobe |
| resAddr | output | TRIAL_W | Result slot index (trial number) |
| resData | output | RES_W | Result word to store |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle end-of-batch pulse |

## Verification
The assertions check the following on every cycle:
- the block is quiet whenever it is idle;
- at most one of the load, ramp, readout and done indications is active;
- the ramp level never falls within a ramp and ends at full scale;
- the readout request follows the ramp at once;
- a write happens only during an acknowledged readout;
- done is a single cycle that directly follows a write.

Some behaviours depend on the configured counts and only the bench scenarios can show them:
- the exact cool-down, settle and ramp lengths;
- the exact ramp value in each cycle;
- the sequence of slot indices and data;
- the trial count in a batch;
- that a mid-batch start or configuration change has no effect.

The bench sweeps zero and small counts, run lengths of one and more, several readout delays, and a full 128-trial batch.

// File: rtl/anneal_seq_pkg.sv
package anneal_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_COOL,
    PH_SETTLE,
    PH_RAMP,
    PH_READ,
    PH_FIN
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic latchCfg;
    logic timerClr;
    logic timerRun;
    logic trialClr;
    logic trialInc;
    logic rampOn;
  } dp_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic coolHit;
    logic settleHit;
    logic runHit;
    logic lastTrial;
  } dp_status_t;

endpackage

// File: rtl/anneal_seq_ctrl.sv
module anneal_seq_ctrl
  import anneal_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       progDone,
  input  logic       readValid,
  input  dp_status_t status,
  output dp_strobe_t strobe,
  output logic       progReq,
  output logic       readReq,
  output logic       rampActive,
  output logic       resWe,
  output logic       busy,
  output logic       done
);

  phase_t phase;
  phase_t nextPhase;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nextPhase;
  end

  always_comb begin
    nextPhase = phase;
    strobe    = '0;
    resWe     = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          nextPhase       = PH_LOAD;
          strobe.latchCfg = 1'b1;
          strobe.trialClr = 1'b1;
          strobe.timerClr = 1'b1;
        end
      end
      PH_LOAD: begin
        if (progDone) begin
          nextPhase       = PH_COOL;
          strobe.timerClr = 1'b1;
        end
      end
      PH_COOL: begin
        strobe.timerRun = 1'b1;
        if (status.coolHit) begin
          nextPhase       = PH_SETTLE;
          strobe.timerClr = 1'b1;
        end
      end
      PH_SETTLE: begin
        strobe.timerRun = 1'b1;
        if (status.settleHit) begin
          nextPhase       = PH_RAMP;
          strobe.timerClr = 1'b1;
        end
      end
      PH_RAMP: begin
        strobe.timerRun = 1'b1;
        strobe.rampOn   = 1'b1;
        if (status.runHit) begin
          nextPhase       = PH_READ;
          strobe.timerClr = 1'b1;
        end
      end
      PH_READ: begin
        if (readValid) begin
          resWe = 1'b1;
          if (status.lastTrial) begin
            nextPhase = PH_FIN;
          end else begin
            nextPhase       = PH_SETTLE;
            strobe.trialInc = 1'b1;
          end
        end
      end
      PH_FIN: nextPhase = PH_IDLE;
      default: nextPhase = PH_IDLE;
    endcase
  end

  assign progReq    = (phase == PH_LOAD);
  assign readReq    = (phase == PH_READ);
  assign rampActive = (phase == PH_RAMP);
  assign busy       = (phase != PH_IDLE) && (phase != PH_FIN);
  assign done       = (phase == PH_FIN);

endmodule

// File: rtl/anneal_seq_dp.sv
module anneal_seq_dp
  import anneal_seq_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int TRIAL_W = 8,
  parameter int RAMP_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_strobe_t         strobe,
  input  logic [CNT_W-1:0]   cfgCool,
  input  logic [CNT_W-1:0]   cfgSettle,
  input  logic [CNT_W-1:0]   cfgRun,
  input  logic [TRIAL_W-1:0] cfgTrials,
  output dp_status_t         status,
  output logic [RAMP_W-1:0]  rampLevel,
  output logic [TRIAL_W-1:0] trialIdx
);

  localparam int PROD_W = CNT_W + RAMP_W;
  localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

  logic [CNT_W-1:0]   coolR, settleR, runR, timer;
  logic [TRIAL_W-1:0] trialsR;

  // zero counts are promoted to one at capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      coolR   <= CNT_W'(1);
      settleR <= CNT_W'(1);
      runR    <= CNT_W'(1);
      trialsR <= TRIAL_W'(1);
    end else if (strobe.latchCfg) begin
      coolR   <= (cfgCool   == '0) ? CNT_W'(1)   : cfgCool;
      settleR <= (cfgSettle == '0) ? CNT_W'(1)   : cfgSettle;
      runR    <= (cfgRun    == '0) ? CNT_W'(1)   : cfgRun;
      trialsR <= (cfgTrials == '0) ? TRIAL_W'(1) : cfgTrials;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                timer <= '0;
    else if (strobe.timerClr) timer <= '0;
    else if (strobe.timerRun) timer <= timer + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                trialIdx <= '0;
    else if (strobe.trialClr) trialIdx <= '0;
    else if (strobe.trialInc) trialIdx <= trialIdx + TRIAL_W'(1);
  end

  assign status.coolHit   = (timer == coolR - CNT_W'(1));
  assign status.settleHit = (timer == settleR - CNT_W'(1));
  assign status.runHit    = (timer == runR - CNT_W'(1));
  assign status.lastTrial = (trialIdx == trialsR - TRIAL_W'(1));

  // level = timer * FULL / (run - 1), computed directly each cycle
  logic [PROD_W-1:0] rampNum, rampDen, rampQuot;
  logic              singleStep;

  assign singleStep = (runR == CNT_W'(1));
  assign rampNum    = PROD_W'(timer) * PROD_W'(FULL);
  assign rampDen    = singleStep ? PROD_W'(1) : PROD_W'(runR - CNT_W'(1));
  assign rampQuot   = rampNum / rampDen;

  always_comb begin
    if (!strobe.rampOn)  rampLevel = '0;
    else if (singleStep) rampLevel = FULL;
    else                 rampLevel = rampQuot[RAMP_W-1:0];
  end

endmodule

// File: rtl/anneal_seq.sv
module anneal_seq
  import anneal_seq_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int TRIAL_W = 8,
  parameter int RAMP_W  = 16,
  parameter int RES_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   cfgCool,
  input  logic [CNT_W-1:0]   cfgSettle,
  input  logic [CNT_W-1:0]   cfgRun,
  input  logic [TRIAL_W-1:0] cfgTrials,
  output logic               progReq,
  input  logic               progDone,
  output logic               rampActive,
  output logic [RAMP_W-1:0]  rampLevel,
  output logic               readReq,
  input  logic               readValid,
  input  logic [RES_W-1:0]   readData,
  output logic               resWe,
  output logic [TRIAL_W-1:0] resAddr,
  output logic [RES_W-1:0]   resData,
  output logic               busy,
  output logic               done
);

  dp_strobe_t strobe;
  dp_status_t status;

  anneal_seq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .progDone   (progDone),
    .readValid  (readValid),
    .status     (status),
    .strobe     (strobe),
    .progReq    (progReq),
    .readReq    (readReq),
    .rampActive (rampActive),
    .resWe      (resWe),
    .busy       (busy),
    .done       (done)
  );

  anneal_seq_dp #(
    .CNT_W   (CNT_W),
    .TRIAL_W (TRIAL_W),
    .RAMP_W  (RAMP_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgCool   (cfgCool),
    .cfgSettle (cfgSettle),
    .cfgRun    (cfgRun),
    .cfgTrials (cfgTrials),
    .status    (status),
    .rampLevel (rampLevel),
    .trialIdx  (resAddr)
  );

  assign resData = readData;

endmodule

// File: rtl/anneal_seq_chk.sv
module anneal_seq_chk #(
  parameter int RAMP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              progReq,
  input logic              rampActive,
  input logic [RAMP_W-1:0] rampLevel,
  input logic              readReq,
  input logic              readValid,
  input logic              resWe,
  input logic              busy,
  input logic              done
);

  localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |-> (!progReq && !rampActive && !readReq && !resWe && rampLevel == '0));

  p_one_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progReq, rampActive, readReq, done}));

  p_ramp_mono_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rampActive && $past(rampActive)) |-> (rampLevel >= $past(rampLevel)));

  p_ramp_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rampActive) |-> ($past(rampLevel) == FULL));

  p_read_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rampActive) |-> readReq);

  p_write_in_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    resWe |-> (readReq && readValid));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(resWe) && !busy));

endmodule

bind anneal_seq anneal_seq_chk #(.RAMP_W(RAMP_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .progReq    (progReq),
  .rampActive (rampActive),
  .rampLevel  (rampLevel),
  .readReq    (readReq),
  .readValid  (readValid),
  .resWe      (resWe),
  .busy       (busy),
  .done       (done)
);

// File: tb/test_anneal_seq.sv
`timescale 1ns/1ps
module test_anneal_seq;

  localparam int CNT_W   = 16;
  localparam int TRIAL_W = 8;
  localparam int RAMP_W  = 8;
  localparam int RES_W   = 8;
  localparam longint FULLV = (1 << RAMP_W) - 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [CNT_W-1:0]   cfgCool = '0, cfgSettle = '0, cfgRun = '0;
  logic [TRIAL_W-1:0] cfgTrials = '0;
  logic               progReq, progDone = 1'b0;
  logic               rampActive;
  logic [RAMP_W-1:0]  rampLevel;
  logic               readReq, readValid = 1'b0;
  logic [RES_W-1:0]   readData = '0;
  logic               resWe;
  logic [TRIAL_W-1:0] resAddr;
  logic [RES_W-1:0]   resData;
  logic               busy, done;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  anneal_seq #(
    .CNT_W(CNT_W), .TRIAL_W(TRIAL_W), .RAMP_W(RAMP_W), .RES_W(RES_W)
  ) i_anneal_seq (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgCool(cfgCool), .cfgSettle(cfgSettle), .cfgRun(cfgRun), .cfgTrials(cfgTrials),
    .progReq(progReq), .progDone(progDone),
    .rampActive(rampActive), .rampLevel(rampLevel),
    .readReq(readReq), .readValid(readValid), .readData(readData),
    .resWe(resWe), .resAddr(resAddr), .resData(resData),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expLevel(input longint k, input longint r);
    if (r == 1) return FULLV;
    return (k * FULLV) / (r - 1);
  endfunction

  function automatic logic [RES_W-1:0] resultOf(input int trial);
    return RES_W'(trial * 37 + 5);
  endfunction

  task automatic runBatch(input int c, input int s, input int r, input int t, input bit poke);
    int effC, effS, effR, effT;
    int gap, expGap, trial, k, rdCnt, cycles, busyBad;
    bit inRamp, finished;
    effC = (c == 0) ? 1 : c;
    effS = (s == 0) ? 1 : s;
    effR = (r == 0) ? 1 : r;
    effT = (t == 0) ? 1 : t;
    @(negedge clk);
    cfgCool = CNT_W'(c); cfgSettle = CNT_W'(s); cfgRun = CNT_W'(r); cfgTrials = TRIAL_W'(t);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      cfgRun = CNT_W'(r + 3); cfgTrials = TRIAL_W'(t + 2); cfgSettle = CNT_W'(s + 4);
    end
    check(progReq == 1'b1, "R2 load request after start", longint'(progReq), 1);
    check(busy == 1'b1, "R7 busy after start", longint'(busy), 1);
    @(negedge clk);
    check(progReq == 1'b1, "R2 load request held", longint'(progReq), 1);
    progDone = 1'b1;
    gap = 0; expGap = effC + effS; trial = 0; k = 0; rdCnt = 0;
    cycles = 0; busyBad = 0; inRamp = 1'b0; finished = 1'b0;
    while (!finished && cycles < 60000) begin
      @(negedge clk);
      progDone = 1'b0;
      readValid = 1'b0;
      cycles++;
      start = poke && (cycles == 3 || cycles == effC + 2);
      if (!busy) busyBad++;
      if (rampActive) begin
        if (!inRamp) begin
          check(gap == expGap, (trial == 0) ? "R3 cool plus settle" : "R5 settle between trials",
                gap, expGap);
          inRamp = 1'b1;
          k = 0;
        end
        check(longint'(rampLevel) == expLevel(k, effR), "R4 ramp level",
              longint'(rampLevel), expLevel(k, effR));
        k++;
      end else begin
        if (inRamp) begin
          check(k == effR, "R4 ramp length", k, effR);
          check(readReq == 1'b1, "R5 readout after ramp", longint'(readReq), 1);
          inRamp = 1'b0;
          rdCnt = 0;
        end
        gap++;
      end
      if (readReq) begin
        if (rdCnt == trial % 3) begin
          readValid = 1'b1;
          readData = resultOf(trial);
          #1;
          check(resWe == 1'b1, "R6 write strobe", longint'(resWe), 1);
          check(resAddr == TRIAL_W'(trial), "R6 slot index", longint'(resAddr), trial);
          check(resData == resultOf(trial), "R6 slot data", longint'(resData), longint'(resultOf(trial)));
          if (trial == effT - 1) finished = 1'b1;
          else begin
            trial++;
            gap = 0;
            expGap = effS;
          end
        end else begin
          #1;
          check(resWe == 1'b0, "R6 no write before valid", longint'(resWe), 0);
          rdCnt++;
        end
      end
    end
    start = 1'b0;
    check(finished, "R6 trial count reached", longint'(trial + 1), effT);
    check(busyBad == 0, "R7 busy held through batch", busyBad, 0);
    @(negedge clk);
    readValid = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R7 done pulse", longint'({done, busy}), 2);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7 idle after done", longint'({done, busy}), 0);
    @(negedge clk);
    check(progReq == 1'b0 && busy == 1'b0, poke ? "R8 no restart from mid-batch start" : "R1 idle quiet",
          longint'({progReq, busy}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && progReq == 1'b0, "R1 reset outputs",
          longint'({busy, done, progReq}), 0);
    check(rampActive == 1'b0 && rampLevel == '0 && readReq == 1'b0, "R1 reset ramp and read",
          longint'({rampActive, readReq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && progReq == 1'b0, "R1 idle after reset", longint'({busy, progReq}), 0);
    // progDone while idle must not start anything
    progDone = 1'b1;
    @(negedge clk);
    progDone = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && rampActive == 1'b0, "R2 progDone ignored while idle",
          longint'({busy, rampActive}), 0);
    for (int c = 0; c <= 2; c += 2)
      for (int s = 0; s <= 3; s += 3)
        for (int ri = 0; ri < 4; ri++)
          for (int t = 0; t <= 3; t += 3)
            runBatch(c, s, (ri == 3) ? 5 : ri, t, 1'b0);
    runBatch(4, 2, 6, 3, 1'b1);
    runBatch(500, 50, 100, 128, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule